// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Slice

This block is a pipelined arithmetic slice for datapaths built from chains of identical cells. Each accepted beat carries an operation code and five operands. The slice adds or subtracts two operands in a narrow pre-adder, multiplies that sum by a third, and adds the product to a wide fourth operand. The fourth operand can come from the local C input, from the previous slice's cascade output, or from the slice's own result register, which turns the slice into an accumulator.

With the multiplier unused, A and B are joined into one wide operand. The slice then adds that operand to C, subtracts it from C, or combines it with C bit by bit. A masked comparator watches the result and flags an exact match with a pattern, or with the complement of that pattern. Typical uses are detecting overflow and ending a count.

All results appear a fixed four clock edges after their inputs are taken, with a valid flag that travels alongside them. The operand registers and the result are passed on to the next slice through the cascade outputs.

Top module: `macc_slice`

## Requirements
- R1: `out_valid` is high in exactly the cycle that follows the fourth rising edge counted from the edge that sampled `in_valid` high, and is low otherwise.
- R2: With opmode 0 the result is P = (D + A[26:0]) * B + C, and with opmode 1 it is P = (D - A[26:0]) * B + C. All operands are two's-complement. The pre-adder wraps to 27 bits and P wraps to 48 bits.
- R3: With opmode 4 the pre-adder is bypassed and P = D * B + C.
- R4: Opmodes 2 and 3 behave like 0 and 1 but add `pcin` in place of C. `pcout` always equals `p_out`.
- R5: With opmode 5, P = P + (D + A[26:0]) * B on each valid beat. P does not change in any cycle that carries no valid beat.
- R6: Let X = {A, B}, with A in bits 47:18 and B in bits 17:0. Opmode 6 gives P = C + X and opmode 7 gives P = C - X, both modulo 2^48.
- R7: Opmodes 8 to 14 give, in order, X&C, X|C, X^C, ~(X&C), ~(X|C), ~(X^C) and ~X.
- R8: `pat_hit` is high when P matches `pattern` on every bit where `mask` is 0. `patb_hit` is high when P matches ~`pattern` on those same bits. Mask bits that are 1 are ignored.
- R9: A synchronous `rst` clears P, `out_valid`, `acout` and `bcout`.
- R10: Opmode 15 loads P with zero.
- R11: `acout` and `bcout` show `a_in` and `b_in` delayed by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Beat present on the operand inputs |
| opmode | input | 4 | Operation code, registered with the operands |
| a_in | input | 30 | Operand A; bits 26:0 feed the pre-adder |
| b_in | input | 18 | Operand B, the multiplier input |
| c_in | input | 48 | Operand C, the wide addend |
| d_in | input | 27 | Operand D, the pre-adder input |
| pcin | input | 48 | Cascade result from the previous slice |
| pattern | input | 48 | Comparison pattern |
| mask | input | 48 | Don't-care mask for the comparison (1 = ignore the bit) |
| out_valid | output | 1 | P holds the result of a new beat |
| p_out | output | 48 | Result register P |
| pcout | output | 48 | Cascade result to the next slice |
| acout | output | 30 | Registered A, passed to the next slice |
| bcout | output | 18 | Registered B, passed to the next slice |
| pat_hit | output | 1 | P matches the pattern on the unmasked bits |
| patb_hit | output | 1 | P matches the inverted pattern on the unmasked bits |

## Verification
The assertions assume that `rst` is held high from time zero for at least one edge, and that `opmode` and the operands are known whenever `in_valid` is high. The bench drives every input to a defined value during reset and only changes inputs at the falling edge. Each sweep pushes single beats through the pipe so that a result can be tied to its operands. Back-to-back beats are sent only in the accumulate run, where idle cycles carrying junk operands are mixed in on purpose.

// File: rtl/macc_pkg.sv
package macc_pkg;

    typedef enum logic [3:0] {
        OP_MAC_C    = 4'd0,
        OP_MSUB_C   = 4'd1,
        OP_MAC_CAS  = 4'd2,
        OP_MSUB_CAS = 4'd3,
        OP_DMUL_C   = 4'd4,
        OP_ACC      = 4'd5,
        OP_WADD     = 4'd6,
        OP_WSUB     = 4'd7,
        OP_AND      = 4'd8,
        OP_OR       = 4'd9,
        OP_XOR      = 4'd10,
        OP_NAND     = 4'd11,
        OP_NOR      = 4'd12,
        OP_XNOR     = 4'd13,
        OP_NOT      = 4'd14,
        OP_CLR      = 4'd15
    } macc_op_e;

    function automatic logic op_uses_cascade(input macc_op_e op);
        return (op == OP_MAC_CAS) || (op == OP_MSUB_CAS);
    endfunction

    function automatic logic op_pre_sub(input macc_op_e op);
        return (op == OP_MSUB_C) || (op == OP_MSUB_CAS);
    endfunction

endpackage

// File: rtl/macc_front.sv
module macc_front
    import macc_pkg::*;
#(
    parameter int A_W = 30,
    parameter int B_W = 18,
    parameter int D_W = 27,
    parameter int P_W = 48
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [3:0]     opmode,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    input  logic [P_W-1:0] c_in,
    input  logic [D_W-1:0] d_in,
    input  logic [P_W-1:0] pcin,
    output logic [A_W-1:0] acout,
    output logic [B_W-1:0] bcout,
    output logic [D_W-1:0] pre_q,
    output logic [B_W-1:0] b_q,
    output logic [P_W-1:0] x_q,
    output logic [P_W-1:0] z_q,
    output macc_op_e       op_q,
    output logic           v_q
);
    // stage 1: input registers
    logic [A_W-1:0] a1;
    logic [B_W-1:0] b1;
    logic [P_W-1:0] c1, pc1;
    logic [D_W-1:0] d1;
    macc_op_e       op1;
    logic           v1;
    logic           armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            a1 <= '0; b1 <= '0; c1 <= '0; d1 <= '0; pc1 <= '0;
            op1 <= OP_MAC_C; v1 <= 1'b0; armed <= 1'b0;
        end else begin
            a1 <= a_in; b1 <= b_in; c1 <= c_in; d1 <= d_in; pc1 <= pcin;
            op1 <= macc_op_e'(opmode); v1 <= in_valid; armed <= 1'b1;
        end
    end

    assign acout = a1;
    assign bcout = b1;

    // stage 2: pre-adder, operand selection
    logic [D_W-1:0] pre_d;
    logic [P_W-1:0] z_d;

    always_comb begin
        if (op1 == OP_DMUL_C)
            pre_d = d1;
        else if (op_pre_sub(op1))
            pre_d = d1 - a1[D_W-1:0];
        else
            pre_d = d1 + a1[D_W-1:0];
        z_d = op_uses_cascade(op1) ? pc1 : c1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0; b_q <= '0; x_q <= '0; z_q <= '0;
            op_q <= OP_MAC_C; v_q <= 1'b0;
        end else begin
            pre_q <= pre_d; b_q <= b1; x_q <= {a1, b1}; z_q <= z_d;
            op_q <= op1; v_q <= v1;
        end
    end

    p_acout_delay_r11: assert property (@(posedge clk) disable iff (rst)
        armed |-> (acout == $past(a_in)));
    p_bcout_delay_r11: assert property (@(posedge clk) disable iff (rst)
        armed |-> (bcout == $past(b_in)));
    p_cas_select_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && (op1 == OP_MAC_CAS)) |=> (z_q == $past(pcin, 2)));

endmodule

// File: rtl/macc_mult.sv
module macc_mult
    import macc_pkg::*;
#(
    parameter int B_W = 18,
    parameter int D_W = 27,
    parameter int P_W = 48
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [D_W-1:0] pre_in,
    input  logic [B_W-1:0] b_in,
    input  logic [P_W-1:0] x_in,
    input  logic [P_W-1:0] z_in,
    input  macc_op_e       op_in,
    input  logic           v_in,
    output logic [P_W-1:0] prod_q,
    output logic [P_W-1:0] x_q,
    output logic [P_W-1:0] z_q,
    output macc_op_e       op_q,
    output logic           v_q
);
    localparam int M_W = D_W + B_W;

    logic signed [M_W-1:0] prod_full;
    assign prod_full = $signed(pre_in) * $signed(b_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0; x_q <= '0; z_q <= '0; op_q <= OP_MAC_C; v_q <= 1'b0;
        end else begin
            prod_q <= {{(P_W-M_W){prod_full[M_W-1]}}, prod_full};
            x_q <= x_in; z_q <= z_in; op_q <= op_in; v_q <= v_in;
        end
    end

    p_zero_operand_r2: assert property (@(posedge clk) disable iff (rst)
        ((b_in == '0) || (pre_in == '0)) |=> (prod_q == '0));

endmodule

// File: rtl/macc_back.sv
module macc_back
    import macc_pkg::*;
#(
    parameter int P_W = 48
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [P_W-1:0] prod_in,
    input  logic [P_W-1:0] x_in,
    input  logic [P_W-1:0] z_in,
    input  macc_op_e       op_in,
    input  logic           v_in,
    output logic [P_W-1:0] p_q,
    output logic           v_q
);
    logic [P_W-1:0] p_d;

    always_comb begin
        unique case (op_in)
            OP_MAC_C, OP_MSUB_C,
            OP_MAC_CAS, OP_MSUB_CAS,
            OP_DMUL_C: p_d = prod_in + z_in;
            OP_ACC:    p_d = p_q + prod_in;
            OP_WADD:   p_d = z_in + x_in;
            OP_WSUB:   p_d = z_in - x_in;
            OP_AND:    p_d = x_in & z_in;
            OP_OR:     p_d = x_in | z_in;
            OP_XOR:    p_d = x_in ^ z_in;
            OP_NAND:   p_d = ~(x_in & z_in);
            OP_NOR:    p_d = ~(x_in | z_in);
            OP_XNOR:   p_d = ~(x_in ^ z_in);
            OP_NOT:    p_d = ~x_in;
            OP_CLR:    p_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= '0;
            v_q <= 1'b0;
        end else begin
            v_q <= v_in;
            if (v_in) p_q <= p_d;
        end
    end

    p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !v_in |=> $stable(p_q));
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> ((p_q == '0) && !v_q));
    p_clear_op_r10: assert property (@(posedge clk) disable iff (rst)
        (v_in && (op_in == OP_CLR)) |=> (p_q == '0));

endmodule

// File: rtl/macc_patdet.sv
module macc_patdet #(
    parameter int P_W = 48
) (
    input  logic [P_W-1:0] p_in,
    input  logic [P_W-1:0] pattern,
    input  logic [P_W-1:0] mask,
    output logic           hit,
    output logic           hit_b
);
    always_comb begin
        hit   = ((p_in ^  pattern) & ~mask) == '0;
        hit_b = ((p_in ^ ~pattern) & ~mask) == '0;
        if (mask == '0) begin
            p_excl_hits_r8: assert (!(hit && hit_b));
        end
    end

endmodule

// File: rtl/macc_slice.sv
module macc_slice
    import macc_pkg::*;
#(
    parameter int A_W = 30,
    parameter int B_W = 18,
    parameter int D_W = 27,
    parameter int P_W = 48
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [3:0]     opmode,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    input  logic [P_W-1:0] c_in,
    input  logic [D_W-1:0] d_in,
    input  logic [P_W-1:0] pcin,
    input  logic [P_W-1:0] pattern,
    input  logic [P_W-1:0] mask,
    output logic           out_valid,
    output logic [P_W-1:0] p_out,
    output logic [P_W-1:0] pcout,
    output logic [A_W-1:0] acout,
    output logic [B_W-1:0] bcout,
    output logic           pat_hit,
    output logic           patb_hit
);
    localparam int LATENCY = 4;

    logic [D_W-1:0] pre2;
    logic [B_W-1:0] b2;
    logic [P_W-1:0] x2, z2, x3, z3, prod3;
    macc_op_e       op2, op3;
    logic           v2, v3;

    macc_front #(.A_W(A_W), .B_W(B_W), .D_W(D_W), .P_W(P_W)) u_front (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opmode(opmode),
        .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in), .pcin(pcin),
        .acout(acout), .bcout(bcout), .pre_q(pre2), .b_q(b2),
        .x_q(x2), .z_q(z2), .op_q(op2), .v_q(v2)
    );

    macc_mult #(.B_W(B_W), .D_W(D_W), .P_W(P_W)) u_mult (
        .clk(clk), .rst(rst), .pre_in(pre2), .b_in(b2), .x_in(x2), .z_in(z2),
        .op_in(op2), .v_in(v2), .prod_q(prod3), .x_q(x3), .z_q(z3),
        .op_q(op3), .v_q(v3)
    );

    macc_back #(.P_W(P_W)) u_back (
        .clk(clk), .rst(rst), .prod_in(prod3), .x_in(x3), .z_in(z3),
        .op_in(op3), .v_in(v3), .p_q(p_out), .v_q(out_valid)
    );

    macc_patdet #(.P_W(P_W)) u_patdet (
        .p_in(p_out), .pattern(pattern), .mask(mask),
        .hit(pat_hit), .hit_b(patb_hit)
    );

    assign pcout = p_out;

    // cycles since reset, saturating, for the latency check
    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 3'(LATENCY))
            since_rst <= since_rst + 3'd1;
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'(LATENCY)) |-> (out_valid == $past(in_valid, 4)));
    p_cascade_out_r4: assert property (@(posedge clk) disable iff (rst)
        pcout == p_out);

endmodule

// File: tb/test_macc_slice.sv
module test_macc_slice;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  opmode = '0;
    logic [29:0] a_in = '0;
    logic [17:0] b_in = '0;
    logic [47:0] c_in = '0;
    logic [26:0] d_in = '0;
    logic [47:0] pcin = '0;
    logic [47:0] pattern = '0;
    logic [47:0] mask = '0;
    logic        out_valid;
    logic [47:0] p_out, pcout;
    logic [29:0] acout;
    logic [17:0] bcout;
    logic        pat_hit, patb_hit;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    macc_slice i_macc_slice (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opmode(opmode),
        .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in), .pcin(pcin),
        .pattern(pattern), .mask(mask), .out_valid(out_valid),
        .p_out(p_out), .pcout(pcout), .acout(acout), .bcout(bcout),
        .pat_hit(pat_hit), .patb_hit(patb_hit)
    );

    task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [47:0] ref_p(input logic [3:0] op, input logic [29:0] a,
        input logic [17:0] b, input logic [47:0] c, input logic [26:0] d,
        input logic [47:0] pc, input logic [47:0] prev);
        longint sa, sd, sb, pre, prod;
        logic [26:0] pre27;
        logic [47:0] x, z, pr;
        sa = longint'($signed(a[26:0]));
        sd = longint'($signed(d));
        sb = longint'($signed(b));
        if (op == 4'd1 || op == 4'd3) pre = sd - sa;
        else if (op == 4'd4)          pre = sd;
        else                          pre = sd + sa;
        pre27 = pre[26:0];
        prod = longint'($signed(pre27)) * sb;
        pr = prod[47:0];
        x = {a, b};
        z = (op == 4'd2 || op == 4'd3) ? pc : c;
        case (op)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4: return pr + z;
            4'd5:  return prev + pr;
            4'd6:  return c + x;
            4'd7:  return c - x;
            4'd8:  return x & c;
            4'd9:  return x | c;
            4'd10: return x ^ c;
            4'd11: return ~(x & c);
            4'd12: return ~(x | c);
            4'd13: return ~(x ^ c);
            4'd14: return ~x;
            default: return '0;
        endcase
    endfunction

    // one isolated beat; checks R1 timing and R11 cascade, returns P
    task automatic run_op(input logic [3:0] op, input logic [29:0] a, input logic [17:0] b,
        input logic [47:0] c, input logic [26:0] d, input logic [47:0] pc,
        output logic [47:0] got);
        @(negedge clk);
        opmode = op; a_in = a; b_in = b; c_in = c; d_in = d; pcin = pc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 acout", 48'(acout), 48'(a));
        check("R11 bcout", 48'(bcout), 48'(b));
        @(negedge clk);
        @(negedge clk);
        check("R1 valid low before latency", 48'(out_valid), 48'd0);
        @(negedge clk);
        check("R1 valid at latency", 48'(out_valid), 48'd1);
        check("R4 pcout mirrors P", pcout, p_out);
        got = p_out;
    endtask

    logic [29:0] av [6] = '{30'h0, 30'h1, 30'h3FFFFFFF, 30'h03FFFFFF, 30'h04000000, 30'h2AAAAAAA};
    logic [26:0] dv [6] = '{27'h0, 27'h1, 27'h7FFFFFF, 27'h3FFFFFF, 27'h4000000, 27'h1234567};
    logic [17:0] bv [5] = '{18'h0, 18'h1, 18'h3FFFF, 18'h1FFFF, 18'h20000};
    logic [47:0] cv [4] = '{48'h0, 48'h1, 48'hFFFF_FFFF_FFFF, 48'h8000_0000_0000};

    initial begin
        logic [47:0] got, acc;
        repeat (3) @(negedge clk);
        check("R9 reset P", p_out, 48'd0);
        check("R9 reset valid", 48'(out_valid), 48'd0);
        check("R9 reset acout", 48'(acout), 48'd0);
        check("R9 reset bcout", 48'(bcout), 48'd0);
        rst = 1'b0;

        // R2, R3: multiply with C over the full operand grid
        foreach (av[i]) foreach (dv[j]) foreach (bv[k]) begin
            for (int op = 0; op < 5; op++) begin
                if (op == 2 || op == 3) continue;
                run_op(4'(op), av[i], bv[k], cv[(i+j+k)%4], dv[j], 48'h0, got);
                check(op == 4 ? "R3 D*B+C" : "R2 pre-add MAC", got,
                      ref_p(4'(op), av[i], bv[k], cv[(i+j+k)%4], dv[j], 48'h0, 48'h0));
            end
        end

        // R4: cascade input replaces C
        foreach (av[i]) foreach (bv[k]) begin
            for (int op = 2; op < 4; op++) begin
                run_op(4'(op), av[i], bv[k], 48'h5555_5555_5555, dv[(i+k)%6], cv[(i+k)%4] ^ 48'h1234, got);
                check("R4 cascade add", got, ref_p(4'(op), av[i], bv[k], 48'h5555_5555_5555,
                      dv[(i+k)%6], cv[(i+k)%4] ^ 48'h1234, 48'h0));
            end
        end

        // R6, R7: wide add/sub and logic over A:B and C
        foreach (av[i]) foreach (bv[k]) foreach (cv[m]) begin
            for (int op = 6; op < 15; op++) begin
                run_op(4'(op), av[i], bv[k], cv[m], 27'h0, 48'h0, got);
                check(op < 8 ? "R6 wide add/sub" : "R7 logic op", got,
                      ref_p(4'(op), av[i], bv[k], cv[m], 27'h0, 48'h0, 48'h0));
            end
        end

        // R10: clear opcode
        run_op(4'd15, 30'h3FFFFFFF, 18'h3FFFF, 48'hFFFF_FFFF_FFFF, 27'h7FFFFFF, 48'h0, got);
        check("R10 clear", got, 48'd0);

        // R5: streaming accumulate with idle beats carrying junk
        acc = '0;
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            opmode = 4'd5; a_in = av[n%6]; b_in = bv[n%5]; d_in = dv[(n+2)%6];
            c_in = 48'hDEAD_BEEF_0000; pcin = 48'h1;
            in_valid = (n % 3) != 2;
            if (in_valid) acc = ref_p(4'd5, a_in, b_in, c_in, d_in, pcin, acc);
        end
        @(negedge clk);
        in_valid = 1'b0; opmode = 4'd15;
        repeat (5) @(negedge clk);
        check("R5 accumulate", p_out, acc);
        repeat (3) @(negedge clk);
        check("R5 hold when idle", p_out, acc);

        // R9: reset mid-run clears P
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R9 mid-run reset P", p_out, 48'd0);
        check("R9 mid-run reset valid", 48'(out_valid), 48'd0);

        // R8: pattern detector on P = C + {A,B}
        run_op(4'd6, 30'h0000_1234, 18'h0ABCD, 48'h0000_0000_0000, 27'h0, 48'h0, got);
        pattern = got; mask = '0;
        #1 check("R8 exact hit", 48'(pat_hit), 48'd1);
        check("R8 exact no inverse hit", 48'(patb_hit), 48'd0);
        pattern = ~got;
        #1 check("R8 inverse hit", 48'(patb_hit), 48'd1);
        check("R8 inverse no hit", 48'(pat_hit), 48'd0);
        pattern = got ^ 48'h0000_0000_000F;
        #1 check("R8 mismatch", 48'(pat_hit), 48'd0);
        mask = 48'h0000_0000_000F;
        #1 check("R8 masked bits ignored", 48'(pat_hit), 48'd1);
        pattern = 48'h0; mask = 48'h0000_FFFF_FFFF_FFFF ^ 48'h0;
        mask = 48'h0000_FFFF_FFFF;
        #1 check("R8 upper-field zero hit", 48'(pat_hit), 48'd1);
        mask = 48'h7FFF_FFFF_FFFF; pattern = 48'h8000_0000_0000;
        #1 check("R8 sign-bit pattern miss", 48'(pat_hit), 48'd0);
        check("R8 sign-bit inverse hit", 48'(patb_hit), 48'd1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule